// File: doc/BRIEF.md
# TDM Bus Contention Detector

This block sits between a set of internal channels and the sixteen serial data lines of a time-division-multiplexed bus. In every timeslot each line may have zero, one or several internal channels enabled onto it. The bits of all enabled channels are combined with a logical AND, and that result is driven onto the line as a wired-AND output. A line with no enabled channel is released: the block holds its output enable low and presents a high level.

While a line is driven, the block compares the bit it drives with the level read back from the bus at the instant given by a sample strobe. A difference means some other device is driving the same timeslot, and it sets that line's sticky error flag. Disagreement among the block's own channels is absorbed by the AND and never counts as an error. One shared active-low control either holds all sixteen flags clear or lets them collect errors. A summary output reports whether any flag is set. Timeslot counting and the channel-to-timeslot map are outside the block and arrive as the per-channel enable inputs.

Top module: `tdm_contention_det`

## Requirements
- R1: `bus_oe[i]` is 1 exactly when at least one of line i's channel enables `ch_en[i*NCH +: NCH]` is 1, in the same cycle (combinational).
- R2: `bus_out[i]` is the AND of `ch_data` over the enabled channels of line i, and is 1 when no channel of the line is enabled.
- R3: With `clr_n` = 1, a rising clock edge at which `sample_stb` = 1, line i is driven and `bus_in[i]` differs from `bus_out[i]` sets line i's error flag, visible after that edge.
- R4: With `sample_stb` = 0 at an edge, no error flag changes, whatever the bus shows.
- R5: A line with no enabled channel never sets its error flag, whatever `bus_in` shows.
- R6: Enabled channels of the same line that carry different bits do not set the flag when the bus shows their AND.
- R7: Once set, an error flag stays set at every edge where `clr_n` = 1, even when the mismatch is gone.
- R8: An edge with `clr_n` = 0 (or `rst` = 1) leaves all sixteen flags clear, and mismatches seen at such an edge are not recorded.
- R9: `err_any` is 1 exactly when at least one of the sixteen error flags is set.
- R10: Flags are reported as two bytes: `err_lo[k]` is line k and `err_hi[k]` is line k+8, for k = 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all flags |
| clr_n | input | 1 | Shared flag control: 0 holds all flags clear, 1 lets them collect |
| sample_stb | input | 1 | One-cycle strobe marking the settled point of the bit period |
| ch_en | input | 16*NCH | Channel enables for the current timeslot, line i at bits [i*NCH +: NCH] |
| ch_data | input | 16*NCH | Channel data bits, same layout as ch_en |
| bus_in | input | 16 | Bus level read back from each line |
| bus_out | output | 16 | Combined wired-AND bit per line, 1 when released |
| bus_oe | output | 16 | Per-line output enable |
| err_lo | output | 8 | Error flags of lines 7..0 |
| err_hi | output | 8 | Error flags of lines 15..8 |
| err_any | output | 1 | OR of all error flags |

## Verification
The assertions assume `bus_in` and the channel inputs are stable and known at each edge where `sample_stb` is 1, and that `rst` is asserted from time zero so the flags start clear. The bench changes every input only on the falling clock edge, so each comparison sees settled values, and it pulses `clr_n` low before each table entry so that every vector starts from clear flags. Lines not under test are kept released with the bus idling high, which keeps stray mismatches out of the flag vector being checked.

// File: rtl/tdm_cd_pkg.sv
package tdm_cd_pkg;

    localparam int LINES  = 16;
    localparam int BYTE_W = 8;

    // Per-line drive decision taken from the enabled channels.
    typedef struct packed {
        logic oe;
        logic bit_v;
    } drv_t;

    // A driven line whose read-back level disagrees at the strobe.
    function automatic logic clash(input drv_t d, input logic bus, input logic stb);
        return stb & d.oe & (d.bit_v ^ bus);
    endfunction

endpackage

// File: rtl/tdm_cd_combine.sv
module tdm_cd_combine
    import tdm_cd_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] dat,
    output drv_t           drv
);

    // Disabled channels contribute a 1, so they never pull the AND low.
    always_comb begin
        drv.oe    = |en;
        drv.bit_v = &(dat | ~en);
    end

endmodule

// File: rtl/tdm_cd_flag.sv
module tdm_cd_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic hit,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || !clr_n) begin
            q <= 1'b0;
        end else if (hit) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/tdm_contention_det.sv
module tdm_contention_det
    import tdm_cd_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_n,
    input  logic                 sample_stb,
    input  logic [16*NCH-1:0]    ch_en,
    input  logic [16*NCH-1:0]    ch_data,
    input  logic [15:0]          bus_in,
    output logic [15:0]          bus_out,
    output logic [15:0]          bus_oe,
    output logic [7:0]           err_lo,
    output logic [7:0]           err_hi,
    output logic                 err_any
);

    drv_t             drv   [LINES];
    logic [LINES-1:0] hit;
    logic [LINES-1:0] flag_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        tdm_cd_combine #(.NCH(NCH)) u_comb (
            .en  (ch_en[i*NCH +: NCH]),
            .dat (ch_data[i*NCH +: NCH]),
            .drv (drv[i])
        );

        assign bus_out[i] = drv[i].bit_v;
        assign bus_oe[i]  = drv[i].oe;
        assign hit[i]     = clash(drv[i], bus_in[i], sample_stb);

        tdm_cd_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .clr_n (clr_n),
            .hit   (hit[i]),
            .q     (flag_q[i])
        );
    end

    assign err_lo  = flag_q[BYTE_W-1:0];
    assign err_hi  = flag_q[LINES-1:BYTE_W];
    assign err_any = |flag_q;

endmodule

// File: rtl/tdm_cd_chk.sv
module tdm_cd_chk (
    input logic        clk,
    input logic        rst,
    input logic        clr_n,
    input logic        sample_stb,
    input logic [15:0] bus_in,
    input logic [15:0] bus_out,
    input logic [15:0] bus_oe,
    input logic [7:0]  err_lo,
    input logic [7:0]  err_hi,
    input logic        err_any
);

    logic [15:0] errv;
    logic [15:0] mism;

    assign errv = {err_hi, err_lo};
    assign mism = bus_oe & (bus_out ^ bus_in) & {16{sample_stb}};

    AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((errv & ~$past(errv) & ~$past(mism)) == 16'h0)); // R3

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> (errv == $past(errv) || $past(!clr_n))); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        ((bus_out | bus_oe) == 16'hFFFF)); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        clr_n |=> ((errv & $past(errv)) == $past(errv))); // R7

    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (errv == 16'h0)); // R8

    AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
        (err_any == (errv != 16'h0))); // R9

endmodule

bind tdm_contention_det tdm_cd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_n      (clr_n),
    .sample_stb (sample_stb),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .err_lo     (err_lo),
    .err_hi     (err_hi),
    .err_any    (err_any)
);

// File: tb/tb_tdm_contention_det.sv
module tb_tdm_contention_det;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              clr_n;
    logic              sample_stb;
    logic [16*NCH-1:0] ch_en;
    logic [16*NCH-1:0] ch_data;
    logic [15:0]       bus_in;
    logic [15:0]       bus_out;
    logic [15:0]       bus_oe;
    logic [7:0]        err_lo;
    logic [7:0]        err_hi;
    logic              err_any;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tdm_contention_det #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .sample_stb(sample_stb),
        .ch_en(ch_en), .ch_data(ch_data), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe),
        .err_lo(err_lo), .err_hi(err_hi), .err_any(err_any)
    );

    // {line[3:0], en[3:0], dat[3:0], bus, stb, exp_out, exp_err}
    localparam logic [15:0] VEC [8] = '{
        16'h011E,  // single channel, bus agrees
        16'h3314,  // two channels disagree, bus shows AND (R6)
        16'h5117,  // external driver pulls low (R3)
        16'h960D,  // driven 0, bus high
        16'hC0F6,  // line released, bus low (R5)
        16'hF882,  // mismatch without strobe (R4)
        16'h7FFE,  // all four channels, bus agrees
        16'h840D   // high byte line (R10)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_lines();
        ch_en      = '0;
        ch_data    = '0;
        bus_in     = 16'hFFFF;
        sample_stb = 1'b0;
    endtask

    task automatic drive_line(input int ln, input logic [3:0] en, input logic [3:0] dat,
                              input logic bus, input logic stb);
        ch_en[ln*NCH +: NCH]   = en;
        ch_data[ln*NCH +: NCH] = dat;
        bus_in[ln]             = bus;
        sample_stb             = stb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst   = 1'b1;
        clr_n = 1'b0;
        idle_lines();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state and R9 summary clear
        check("R8 reset flags", {err_hi, err_lo}, 16'h0);
        check("R9 reset summary", err_any, 0);
        check("R1 reset oe idle", bus_oe, 16'h0);
        check("R2 released lines high", bus_out, 16'hFFFF);

        // Table walk
        foreach (VEC[v]) begin
            int ln;
            logic [3:0] en, dat;
            logic bus, stb, eo, ee;
            {ln[3:0], en, dat, bus, stb, eo, ee} = VEC[v];
            ln[31:4] = '0;
            clr_n = 1'b0;
            idle_lines();
            step();
            clr_n = 1'b1;
            drive_line(ln, en, dat, bus, stb);
            #1;
            check("R1 oe", bus_oe, (en != 4'h0) ? (32'h1 << ln) : 32'h0);
            check("R2 out", bus_out[ln], eo);
            @(negedge clk);
            sample_stb = 1'b0;
            #1;
            check("R3/R4/R5/R6 flags", {err_hi, err_lo}, ee ? (32'h1 << ln) : 32'h0);
            check("R9 summary", err_any, ee);
            if (ln >= 8) check("R10 high byte", err_hi, ee ? (32'h1 << (ln - 8)) : 32'h0);
            else         check("R10 low byte", err_lo, ee ? (32'h1 << ln) : 32'h0);
        end

        // R7 stickiness across agreeing samples and a second line
        clr_n = 1'b0;
        idle_lines();
        step();
        clr_n = 1'b1;
        drive_line(2, 4'h1, 4'h1, 1'b0, 1'b1);
        step();
        idle_lines();
        drive_line(2, 4'h1, 4'h1, 1'b1, 1'b1);
        step();
        check("R7 sticky after agree", err_lo, 8'h04);
        idle_lines();
        drive_line(10, 4'h2, 4'h0, 1'b1, 1'b1);
        step();
        idle_lines();
        repeat (3) step();
        check("R7 two flags held", {err_hi, err_lo}, 16'h0404);
        check("R10 line 10 in high byte", err_hi, 8'h04);
        check("R9 summary with two", err_any, 1);

        // R8 clear while mismatch present
        clr_n = 1'b0;
        drive_line(4, 4'h1, 4'h0, 1'b1, 1'b1);
        step();
        check("R8 cleared", {err_hi, err_lo}, 16'h0);
        step();
        check("R8 mismatch ignored while held", {err_hi, err_lo}, 16'h0);
        check("R9 summary cleared", err_any, 0);
        clr_n = 1'b1;
        step();
        check("R3 set once enabled", err_lo, 8'h10);

        // R8 reset also clears
        rst = 1'b1;
        idle_lines();
        step();
        rst = 1'b0;
        #1;
        check("R8 reset clears set flag", {err_hi, err_lo}, 16'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule